// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps the bookkeeping for packets that sit in a receive byte FIFO, without holding the data itself. The receive side marks the start of each packet, strobes once for every byte it pushes, and marks the end together with a 4-bit error code. The host side pops single bytes from the oldest packet or drops that packet whole. From this traffic the block keeps a ring of per-packet records and presents a 16-bit status word for the oldest record.

The status word layout is fixed because host software decodes it. Bit 15 means "nothing complete to report". Bits 14 to 11 carry the error class, with bit 14 doubling as the error flag. Bits 10 to 0 carry the number of unread bytes in the oldest packet. The block enforces a packet-count limit and a byte-capacity limit, and reports each through its own self-clearing flag. An over-read by the host raises a sticky fault that only a reset removes. The block also drives a receiving indicator, a packet-complete level and a one-shot early-receive event tied to a programmable byte threshold.

Top module: `rxq_status_queue`

## Requirements
- R1: After `rst_n` low, `status_word` is 16'h8000, and every diagnostic flag, `rx_complete`, `rx_early` and `adapter_fail` are 0.
- R2: When the queue is empty, or its oldest packet has not ended, bit 15 is 1 and bits 14..11 are 0. Bits 10..0 always give the unread byte count of the oldest packet, or 0 when the queue is empty.
- R3: At `rx_end`, `rx_err` is stored and reported in bits 14..11 once the packet is oldest. The codes 4'b1000, 4'b1001, 4'b1011, 4'b1100 and 4'b1101 are kept and so have bit 14 set. The code 4'b0010 (dribble) is kept with bit 14 clear. Every other code is reported as 4'b0000.
- R4: A byte strobed while the FIFO holds `FIFO_BYTES` bytes is dropped, and `diag_rx_ovr` rises. That packet ends with class 4'b1000 whatever `rx_err` says. The flag clears after the host removes at least one byte.
- R5: A start arriving while `MAX_PKTS` packets are queued is rejected, and `diag_stat_ovr` rises. The rejected packet's bytes and end leave no record. The flag clears when a discard removes a packet.
- R6: Each `host_rd` lowers the oldest packet's unread count by one. A `host_rd` with an empty queue, or with no unread byte in the oldest packet, sets `diag_rx_udr` and `adapter_fail`. Both stay set until `rx_reset` or `rst_n`.
- R7: `diag_receiving` is 1 from the cycle after an accepted start until the cycle after that packet's end.
- R8: `host_discard` removes the oldest packet and frees its unread bytes, and the next packet becomes the oldest. A discard with an empty queue has no effect. Discarding a packet that is still arriving drops the rest of its bytes and its end.
- R9: `rx_complete` is 1 exactly while a queued oldest packet has ended.
- R10: `rx_early` pulses for one cycle when the arriving packet's accepted byte count becomes equal to a nonzero `early_thresh`. It pulses at most once per packet.
- R11: `rx_reset` empties the queue and clears every flag, including the sticky underrun.
- R12: When `host_discard` and `host_rd` are strobed in the same cycle, only the discard acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| rx_reset | input | 1 | Synchronous receive-path reset |
| rx_start | input | 1 | First strobe of a new packet |
| rx_byte | input | 1 | One byte pushed into the FIFO |
| rx_end | input | 1 | Packet finished; `rx_err` is valid |
| rx_err | input | 4 | Error code of the ending packet |
| early_thresh | input | 11 | Byte count that fires `rx_early`, 0 disables it |
| host_rd | input | 1 | Host pops one byte of the oldest packet |
| host_discard | input | 1 | Host drops the oldest packet |
| status_word | output | 16 | Status of the oldest packet |
| diag_receiving | output | 1 | A packet is being written |
| diag_stat_ovr | output | 1 | Packet-count limit hit |
| diag_rx_ovr | output | 1 | Byte capacity hit |
| diag_rx_udr | output | 1 | Host over-read, sticky |
| rx_complete | output | 1 | Oldest packet has ended |
| rx_early | output | 1 | Early-receive event pulse |
| adapter_fail | output | 1 | Fault raised by an over-read |

## Verification
All state sits in one register stage, and `status_word` is decoded straight from it. Every result of a strobe is therefore visible one clock edge after the edge that samples that strobe, and the `rx_early` pulse lasts exactly that one cycle. The bench applies each strobe for one cycle starting at a falling edge. It reads the outputs at the next falling edge, after the capturing rising edge and before new inputs are applied. Sticky and self-clearing behaviour is checked by reading the flags again over later cycles, with no strobe or with unrelated strobes applied.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int LEN_W = 11;

    typedef enum logic [1:0] {
        RXM_IDLE = 2'd0,
        RXM_FILL = 2'd1,
        RXM_DROP = 2'd2
    } rx_mode_e;

    localparam logic [3:0] CLS_NONE     = 4'b0000;
    localparam logic [3:0] CLS_OVERRUN  = 4'b1000;
    localparam logic [3:0] CLS_OVERSIZE = 4'b1001;
    localparam logic [3:0] CLS_RUNT     = 4'b1011;
    localparam logic [3:0] CLS_ALIGN    = 4'b1100;
    localparam logic [3:0] CLS_CRC      = 4'b1101;
    localparam logic [3:0] CLS_DRIBBLE  = 4'b0010;
endpackage

// File: rtl/rxq_err_map.sv
module rxq_err_map
    import rxq_pkg::*;
(
    input  logic [3:0] code_i,
    input  logic       lost_i,
    output logic [3:0] cls_o
);
    always_comb begin
        if (lost_i) begin
            cls_o = CLS_OVERRUN;
        end else begin
            unique case (code_i)
                CLS_OVERRUN, CLS_OVERSIZE, CLS_RUNT,
                CLS_ALIGN, CLS_CRC, CLS_DRIBBLE: cls_o = code_i;
                default:                         cls_o = CLS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/rxq_status_fmt.sv
module rxq_status_fmt
    import rxq_pkg::*;
(
    input  logic             have_i,
    input  logic             done_i,
    input  logic [3:0]       cls_i,
    input  logic [LEN_W-1:0] rem_i,
    output logic [15:0]      word_o
);
    logic ready;

    always_comb begin
        ready  = have_i && done_i;
        word_o = {~ready, (ready ? cls_i : 4'b0000), (have_i ? rem_i : {LEN_W{1'b0}})};
    end
endmodule

// File: rtl/rxq_status_queue.sv
module rxq_status_queue
    import rxq_pkg::*;
#(
    parameter int MAX_PKTS   = 8,
    parameter int FIFO_BYTES = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_reset,
    input  logic             rx_start,
    input  logic             rx_byte,
    input  logic             rx_end,
    input  logic [3:0]       rx_err,
    input  logic [LEN_W-1:0] early_thresh,
    input  logic             host_rd,
    input  logic             host_discard,
    output logic [15:0]      status_word,
    output logic             diag_receiving,
    output logic             diag_stat_ovr,
    output logic             diag_rx_ovr,
    output logic             diag_rx_udr,
    output logic             rx_complete,
    output logic             rx_early,
    output logic             adapter_fail
);
    localparam int PTR_W = (MAX_PKTS > 1) ? $clog2(MAX_PKTS) : 1;
    localparam int CNT_W = $clog2(MAX_PKTS + 1);
    localparam int OCC_W = $clog2(FIFO_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PKTS);
    localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(FIFO_BYTES);

    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic             done;
        logic             lost;
        logic [3:0]       cls;
    } slot_t;

    typedef struct packed {
        slot_t [MAX_PKTS-1:0] slots;
        logic [PTR_W-1:0]     head;
        logic [CNT_W-1:0]     cnt;
        logic [OCC_W-1:0]     occ;
        rx_mode_e             mode;
        logic [LEN_W-1:0]     len;
        logic                 stat_ovr;
        logic                 rx_ovr;
        logic                 udr;
        logic                 early;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] off);
        int s;
        s = (int'(p) + int'(off)) % MAX_PKTS;
        return PTR_W'(s);
    endfunction

    logic             have_head;
    logic             new_pkt, rej_pkt, filling;
    logic             byte_take, byte_lost, end_here;
    logic [PTR_W-1:0] tail_idx;
    logic             tail_lost;
    logic [3:0]       end_cls;
    logic [LEN_W-1:0] len_base, len_next;
    slot_t            head_q;

    always_comb begin
        have_head = (st_q.cnt != '0);
        head_q    = st_q.slots[st_q.head];
        new_pkt   = rx_start && (st_q.mode == RXM_IDLE) && (st_q.cnt != CNT_MAX);
        rej_pkt   = rx_start && (st_q.mode == RXM_IDLE) && (st_q.cnt == CNT_MAX);
        filling   = new_pkt || (st_q.mode == RXM_FILL);
        if (new_pkt)        tail_idx = ring_add(st_q.head, st_q.cnt);
        else if (have_head) tail_idx = ring_add(st_q.head, st_q.cnt - 1'b1);
        else                tail_idx = st_q.head;
        byte_take = filling && rx_byte && (st_q.occ != OCC_MAX);
        byte_lost = filling && rx_byte && (st_q.occ == OCC_MAX);
        end_here  = filling && rx_end;
        tail_lost = (new_pkt ? 1'b0 : st_q.slots[tail_idx].lost) | byte_lost;
        len_base  = new_pkt ? '0 : st_q.len;
        len_next  = (len_base == {LEN_W{1'b1}}) ? len_base : len_base + 1'b1;
    end

    rxq_err_map u_err_map (
        .code_i (rx_err),
        .lost_i (tail_lost),
        .cls_o  (end_cls)
    );

    always_comb begin
        st_d       = st_q;
        st_d.early = 1'b0;

        // receive side: start, then byte, then end
        if (new_pkt) begin
            st_d.slots[tail_idx] = '0;
            st_d.cnt             = st_q.cnt + 1'b1;
            st_d.mode            = RXM_FILL;
            st_d.len             = '0;
        end
        if (rej_pkt) begin
            st_d.mode = RXM_DROP;
        end
        if (byte_take) begin
            st_d.slots[tail_idx].rem = st_d.slots[tail_idx].rem + 1'b1;
            st_d.occ                 = st_q.occ + 1'b1;
            st_d.len                 = len_next;
            st_d.early               = (early_thresh != '0) && (len_next == early_thresh)
                                       && (len_base != early_thresh);
        end
        if (byte_lost) begin
            st_d.slots[tail_idx].lost = 1'b1;
        end
        if (end_here) begin
            st_d.slots[tail_idx].done = 1'b1;
            st_d.slots[tail_idx].cls  = end_cls;
            st_d.mode                 = RXM_IDLE;
        end
        if ((rej_pkt || st_q.mode == RXM_DROP) && rx_end) begin
            st_d.mode = RXM_IDLE;
        end

        // host side: discard wins over a same-cycle read
        if (host_discard) begin
            if (have_head) begin
                st_d.occ      = st_d.occ - OCC_W'(st_d.slots[st_q.head].rem);
                if (st_d.slots[st_q.head].rem != '0) st_d.rx_ovr = 1'b0;
                if (!st_d.slots[st_q.head].done && st_d.mode == RXM_FILL)
                    st_d.mode = RXM_DROP;
                st_d.head     = ring_add(st_q.head, CNT_W'(1));
                st_d.cnt      = st_d.cnt - 1'b1;
                st_d.stat_ovr = 1'b0;
            end
        end else if (host_rd) begin
            if (have_head && head_q.rem != '0) begin
                st_d.slots[st_q.head].rem = st_d.slots[st_q.head].rem - 1'b1;
                st_d.occ                  = st_d.occ - 1'b1;
                st_d.rx_ovr               = 1'b0;
            end else begin
                st_d.udr = 1'b1;
            end
        end

        // a limit hit in this cycle outranks a clear
        if (rej_pkt)   st_d.stat_ovr = 1'b1;
        if (byte_lost) st_d.rx_ovr   = 1'b1;

        if (rx_reset) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxq_status_fmt u_status_fmt (
        .have_i (have_head),
        .done_i (head_q.done),
        .cls_i  (head_q.cls),
        .rem_i  (head_q.rem),
        .word_o (status_word)
    );

    assign diag_receiving = (st_q.mode == RXM_FILL);
    assign diag_stat_ovr  = st_q.stat_ovr;
    assign diag_rx_ovr    = st_q.rx_ovr;
    assign diag_rx_udr    = st_q.udr;
    assign rx_complete    = have_head && head_q.done;
    assign rx_early       = st_q.early;
    assign adapter_fail   = st_q.udr;

    // R5: the record count never passes the packet limit
    a_r5_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R4: byte occupancy never passes the capacity
    a_r4_occ_limit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= OCC_MAX);

    // R6: the over-read fault holds until a receive reset
    a_r6_udr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_rx_udr && !rx_reset) |=> diag_rx_udr);

    // R7: while receiving there is a record to write into
    a_r7_fill_has_slot: assert property (@(posedge clk) disable iff (!rst_n)
        diag_receiving |-> (st_q.cnt != '0));

    // R2: an empty queue reports bit 15 and a zero count
    a_r2_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> (status_word[15] && status_word[10:0] == '0));

    // R9: a complete head never shows bit 15
    a_r9_complete_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !status_word[15]);

    // R11: a receive reset empties the queue and drops the fault
    a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (st_q.cnt == '0 && !diag_rx_udr && !diag_receiving));
endmodule

// File: tb/rxq_status_queue_bench.sv
module rxq_status_queue_bench;
    localparam int NPK  = 8;
    localparam int CAP  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_reset = 1'b0;
    logic        rx_start = 1'b0, rx_byte = 1'b0, rx_end = 1'b0;
    logic [3:0]  rx_err = '0;
    logic [10:0] early_thresh = '0;
    logic        host_rd = 1'b0, host_discard = 1'b0;
    logic [15:0] status_word;
    logic        diag_receiving, diag_stat_ovr, diag_rx_ovr, diag_rx_udr;
    logic        rx_complete, rx_early, adapter_fail;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rxq_status_queue #(.MAX_PKTS(NPK), .FIFO_BYTES(CAP)) u_rxq_status_queue (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
        .rx_start(rx_start), .rx_byte(rx_byte), .rx_end(rx_end), .rx_err(rx_err),
        .early_thresh(early_thresh), .host_rd(host_rd), .host_discard(host_discard),
        .status_word(status_word), .diag_receiving(diag_receiving),
        .diag_stat_ovr(diag_stat_ovr), .diag_rx_ovr(diag_rx_ovr),
        .diag_rx_udr(diag_rx_udr), .rx_complete(rx_complete),
        .rx_early(rx_early), .adapter_fail(adapter_fail)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle of strobes, starting and ending on a falling edge
    task automatic drive(input logic s, input logic b, input logic e,
                         input logic [3:0] err, input logic r, input logic d);
        rx_start = s; rx_byte = b; rx_end = e; rx_err = err;
        host_rd = r; host_discard = d;
        @(negedge clk);
        rx_start = 0; rx_byte = 0; rx_end = 0; rx_err = '0;
        host_rd = 0; host_discard = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_rx_reset();
        rx_reset = 1'b1;
        @(negedge clk);
        rx_reset = 1'b0;
    endtask

    function automatic logic [3:0] exp_cls(input logic [3:0] c);
        case (c)
            4'b1000, 4'b1001, 4'b1011, 4'b1100, 4'b1101, 4'b0010: return c;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic t_reset_state();
        chk("R1 status", status_word, 16'h8000);
        chk("R1 flags", {12'b0, diag_receiving, diag_stat_ovr, diag_rx_ovr, diag_rx_udr}, 16'h0);
        chk("R1 events", {13'b0, rx_complete, rx_early, adapter_fail}, 16'h0);
    endtask

    task automatic t_basic();
        drive(1, 1, 0, 0, 0, 0);
        chk("R7 receiving after start", {15'b0, diag_receiving}, 16'h1);
        chk("R2 first byte", status_word, 16'h8001);
        for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 0, 0);
        chk("R2 incomplete count", status_word, 16'h8005);
        chk("R9 not complete yet", {15'b0, rx_complete}, 16'h0);
        drive(0, 0, 1, 4'h0, 0, 0);
        chk("R7 receiving after end", {15'b0, diag_receiving}, 16'h0);
        chk("R9 complete", {15'b0, rx_complete}, 16'h1);
        chk("R2 done word", status_word, 16'h0005);
        drive(0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 1, 0);
        chk("R6 two reads", status_word, 16'h0003);
        drive(0, 0, 0, 0, 0, 1);
        chk("R8 discard empties", status_word, 16'h8000);
        chk("R9 empty not complete", {15'b0, rx_complete}, 16'h0);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 16; c++) begin
            drive(1, 1, 0, 0, 0, 0);
            drive(0, 0, 1, 4'(c), 0, 0);
            chk($sformatf("R3 code %0d", c), status_word, {1'b0, exp_cls(4'(c)), 11'd1});
            drive(0, 0, 0, 0, 0, 1);
        end
    endtask

    task automatic t_early();
        int pulses = 0;
        early_thresh = 11'd3;
        drive(1, 1, 0, 0, 0, 0);
        chk("R10 no pulse at 1", {15'b0, rx_early}, 16'h0);
        drive(0, 1, 0, 0, 0, 0);
        chk("R10 no pulse at 2", {15'b0, rx_early}, 16'h0);
        drive(0, 1, 0, 0, 0, 0);
        chk("R10 pulse at 3", {15'b0, rx_early}, 16'h1);
        for (int i = 0; i < 3; i++) begin
            drive(0, 1, 0, 0, 0, 0);
            if (rx_early) pulses++;
        end
        drive(0, 0, 1, 0, 0, 0);
        if (rx_early) pulses++;
        chk("R10 single pulse", 16'(pulses), 16'h0);
        drive(0, 0, 0, 0, 0, 1);
        early_thresh = '0;
        pulses = 0;
        drive(1, 1, 0, 0, 0, 0);
        if (rx_early) pulses++;
        for (int i = 0; i < 3; i++) begin
            drive(0, 1, 0, 0, 0, 0);
            if (rx_early) pulses++;
        end
        drive(0, 0, 1, 0, 0, 1);
        chk("R10 zero threshold silent", 16'(pulses), 16'h0);
        drive(0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_pkt_limit();
        for (int i = 0; i < NPK; i++) drive(1, 1, 1, 0, 0, 0);
        chk("R5 no flag at limit", {15'b0, diag_stat_ovr}, 16'h0);
        drive(1, 1, 0, 0, 0, 0);
        chk("R5 flag on rejected start", {15'b0, diag_stat_ovr}, 16'h1);
        chk("R7 rejected not receiving", {15'b0, diag_receiving}, 16'h0);
        drive(0, 1, 0, 0, 0, 0);
        drive(0, 0, 1, 4'hD, 0, 0);
        chk("R5 flag holds", {15'b0, diag_stat_ovr}, 16'h1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R5 flag clears on discard", {15'b0, diag_stat_ovr}, 16'h0);
        chk("R8 next head", status_word, 16'h0001);
        for (int i = 0; i < NPK - 1; i++) drive(0, 0, 0, 0, 0, 1);
        chk("R5 rejected left no record", status_word, 16'h8000);
    endtask

    task automatic t_fifo_full();
        drive(1, 1, 0, 0, 0, 0);
        for (int i = 1; i < CAP; i++) drive(0, 1, 0, 0, 0, 0);
        chk("R4 no flag when just full", {15'b0, diag_rx_ovr}, 16'h0);
        drive(0, 1, 0, 0, 0, 0);
        chk("R4 flag on dropped byte", {15'b0, diag_rx_ovr}, 16'h1);
        drive(0, 0, 1, 4'h0, 0, 0);
        chk("R4 overrun class", status_word, 16'h4000 | 16'(CAP));
        chk("R4 flag holds", {15'b0, diag_rx_ovr}, 16'h1);
        drive(0, 0, 0, 0, 1, 0);
        chk("R4 flag clears on read", {15'b0, diag_rx_ovr}, 16'h0);
        chk("R6 count after read", status_word, 16'h4000 | 16'(CAP - 1));
        drive(0, 0, 0, 0, 0, 1);
        chk("R8 space freed", status_word, 16'h8000);
        drive(1, 1, 1, 0, 0, 0);
        chk("R8 bytes freed by discard", status_word, 16'h0001);
        drive(0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_discard_live();
        drive(0, 0, 0, 0, 0, 1);
        chk("R8 discard on empty", status_word, 16'h8000);
        chk("R8 discard on empty flags", {12'b0, diag_receiving, diag_stat_ovr, diag_rx_ovr, diag_rx_udr}, 16'h0);
        drive(1, 1, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1);
        chk("R8 live discard empties", status_word, 16'h8000);
        chk("R8 live discard stops receiving", {15'b0, diag_receiving}, 16'h0);
        drive(0, 1, 0, 0, 0, 0);
        drive(0, 1, 1, 4'hD, 0, 0);
        chk("R8 tail bytes dropped", status_word, 16'h8000);
        chk("R9 tail end ignored", {15'b0, rx_complete}, 16'h0);
        drive(1, 1, 1, 0, 0, 0);
        chk("R8 next packet normal", status_word, 16'h0001);
        drive(0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_priority();
        drive(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0);
        drive(0, 1, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 1);
        chk("R12 discard wins, next head untouched", status_word, 16'h0002);
        chk("R12 no fault from read", {15'b0, diag_rx_udr}, 16'h0);
        drive(0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_underrun();
        drive(0, 0, 0, 0, 1, 0);
        chk("R6 empty read fault", {14'b0, diag_rx_udr, adapter_fail}, 16'h3);
        idle(3);
        chk("R6 fault sticky idle", {14'b0, diag_rx_udr, adapter_fail}, 16'h3);
        drive(1, 1, 0, 0, 0, 0);
        drive(0, 1, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1);
        chk("R6 fault sticky traffic", {15'b0, diag_rx_udr}, 16'h1);
        pulse_rx_reset();
        chk("R11 fault cleared", {14'b0, diag_rx_udr, adapter_fail}, 16'h0);
        drive(1, 1, 0, 0, 0, 0);
        drive(0, 1, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 1, 0);
        chk("R6 legal reads no fault", {15'b0, diag_rx_udr}, 16'h0);
        chk("R6 count drained", status_word, 16'h0000);
        drive(0, 0, 0, 0, 1, 0);
        chk("R6 over-read fault", {14'b0, diag_rx_udr, adapter_fail}, 16'h3);
        pulse_rx_reset();
    endtask

    task automatic t_rx_reset();
        drive(1, 1, 1, 4'hB, 0, 0);
        drive(1, 1, 1, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 1, 0);
        pulse_rx_reset();
        chk("R11 status", status_word, 16'h8000);
        chk("R11 flags", {12'b0, diag_receiving, diag_stat_ovr, diag_rx_ovr, diag_rx_udr}, 16'h0);
        chk("R11 events", {13'b0, rx_complete, rx_early, adapter_fail}, 16'h0);
        drive(1, 1, 1, 0, 0, 0);
        chk("R11 usable after reset", status_word, 16'h0001);
    endtask

    initial begin
        #2_000_000;
        fails++;
        total++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_codes();
        t_early();
        t_pkt_limit();
        t_fifo_full();
        t_discard_live();
        t_priority();
        t_underrun();
        t_rx_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule